// File: doc/BRIEF.md
# Spare Rank Failover Controller

This controller looks after one memory channel that has several working ranks and one reserve rank. It counts correctable error reports for each working rank inside a repeating time window. When one rank collects too many errors inside a single window, the controller moves that rank's contents onto the reserve rank. While the move runs, host writes aimed at the failing rank go to both ranks. A background engine copies every word across and then reads the two ranks back side by side to confirm that they match.

The reserve rank carries rank ID `NRANK` and is never reachable by the host. Once the comparison has matched at every address, the failing rank's ID is remapped so that it points at the reserve rank, and the failing rank is not written again. The reserve can serve only one failover. A later error burst only raises a sticky alarm. If the configured reserve capacity is smaller than the largest working rank, the controller does not migrate and reports that no spare is available.

The memory itself sits outside this block. It is reached through:
- a primary write port;
- a spare write port;
- one read port for any rank;
- one read port for the spare.

Both read ports return data one cycle after the request. The data returned reflects the memory contents from before any write made in the same cycle.

Top module: `spare_failover_ctrl`

## Requirements
- R1: During and right after a synchronous active-low reset, `status` is 0 (normal), `alarm` is 0, and no spare write or copy read is issued.
- R2: A host write to rank ID `NRANK` (the spare) is dropped, so `m_wr_valid` stays 0. Outside the spared state, no primary write carries rank ID `NRANK`. Writes to any other rank pass straight through with the same rank, address and data.
- R3: A window timer starts at 0 after reset and wraps every `cfg_window` cycles, and at each wrap the per-rank error counts clear. An error report that brings one rank's count to `cfg_threshold` inside the current window moves `status` to 1 (migrating) on the next clock. Errors split across windows do not trigger.
- R4: While `status` is 1 or 2, a host write to the failing rank is also issued, in the same cycle, on the spare write port with the same address and data. Host writes to other ranks are not mirrored.
- R5: When migration completes, every address of the spare holds the same value as the failing rank, including addresses the host wrote while the copy was running.
- R6: After the copy, `status` becomes 2 (verify) and both ranks are read and compared word by word. A mismatch returns `status` to 1 and the copy restarts from address 0. `status` becomes 3 (spared) only straight from 2.
- R7: In state 3, a host write to the failed rank ID goes out on the primary port with rank ID `NRANK`. The failed rank is never written again.
- R8: If `cfg_spare_words` is less than `cfg_rank_words` when the threshold is reached, `status` becomes 4 (no spare) and no mirror or copy traffic reaches the spare port.
- R9: In state 3 or 4, a further threshold event sets `alarm` to 1, and `alarm` stays at 1 until reset. `status` never leaves 3 once reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_threshold | input | CNT_W | Errors per window that trigger failover |
| cfg_window | input | WIN_W | Window length in cycles |
| cfg_spare_words | input | ADDR_W+1 | Capacity of the spare rank in words |
| cfg_rank_words | input | ADDR_W+1 | Capacity of the largest working rank in words |
| err_valid | input | 1 | Correctable error report |
| err_rank | input | RW | Rank ID of the error report |
| wr_valid | input | 1 | Host write request |
| wr_rank | input | RW | Host write rank ID |
| wr_addr | input | ADDR_W | Host write word address |
| wr_data | input | DATA_W | Host write data |
| m_wr_valid | output | 1 | Primary memory write |
| m_wr_rank | output | RW | Primary write rank after remap |
| m_wr_addr | output | ADDR_W | Primary write address |
| m_wr_data | output | DATA_W | Primary write data |
| s_wr_valid | output | 1 | Spare rank write (mirror or copy) |
| s_wr_addr | output | ADDR_W | Spare write address |
| s_wr_data | output | DATA_W | Spare write data |
| m_rd_valid | output | 1 | Copy engine read of the failing rank |
| m_rd_rank | output | RW | Rank read by the copy engine |
| m_rd_addr | output | ADDR_W | Copy engine read address |
| m_rd_data | input | DATA_W | Read data, one cycle after request |
| s_rd_valid | output | 1 | Verify read of the spare |
| s_rd_addr | output | ADDR_W | Spare read address |
| s_rd_data | input | DATA_W | Spare read data, one cycle after request |
| status | output | 3 | 0 normal, 1 migrating, 2 verify, 3 spared, 4 no spare |
| failed_rank | output | RW | Rank ID that crossed the threshold |
| alarm | output | 1 | Sticky alarm for a threshold event after the spare is used or unavailable |

## Verification
If an error counter is stuck or the window fails to clear, `status` moves to 1 one cycle too early or at the wrong time, and this shows on the first aligned error burst. A broken mirror or copy retry rule leaves the spare different from the failing rank. That difference appears either as a verify mismatch that sends `status` back to 1, or as a word difference in the memory model once state 3 is reached, within about four passes over the rank. A wrong remap or spare-hiding decision shows up combinationally on the primary write port in the same cycle as the host write.

// File: rtl/sfo_pkg.sv
// Shared types for the spare rank failover controller.
package sfo_pkg;
    // Channel status as seen at the status port.
    typedef enum logic [2:0] {
        ST_NORMAL  = 3'd0,
        ST_MIGRATE = 3'd1,
        ST_VERIFY  = 3'd2,
        ST_SPARED  = 3'd3,
        ST_NOSPARE = 3'd4
    } sfo_state_e;

    // Copy engine phase.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_CRD  = 3'd1,
        PH_CWR  = 3'd2,
        PH_VRD  = 3'd3,
        PH_VCMP = 3'd4
    } sfo_phase_e;
endpackage

// File: rtl/sfo_err_monitor.sv
// Error-rate monitor.
// Counts error reports per working rank inside a repeating window of
// cfg_window cycles and raises trig when a report brings a rank's count to
// cfg_threshold. Assumes cfg_window >= 1. Counters saturate and clear at wrap.
module sfo_err_monitor #(
    parameter int NRANK = 4,
    parameter int CNT_W = 4,
    parameter int WIN_W = 8,
    parameter int RW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_threshold,
    input  logic [WIN_W-1:0] cfg_window,
    input  logic             err_valid,
    input  logic [RW-1:0]    err_rank,
    output logic             trig
);
    logic [WIN_W-1:0] tmr;
    logic             wrap;
    logic [CNT_W-1:0] cnt [NRANK];
    logic [NRANK-1:0] hit_vec;
    logic [NRANK-1:0] reach_vec;

    assign wrap = ({1'b0, tmr} + 1'b1) >= {1'b0, cfg_window};

    // Window timer: counts cycles and restarts at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n)    tmr <= '0;
        else if (wrap) tmr <= '0;
        else           tmr <= tmr + 1'b1;
    end

    for (genvar r = 0; r < NRANK; r++) begin : g_rank
        assign hit_vec[r]   = err_valid && (err_rank == RW'(r));
        assign reach_vec[r] = ({1'b0, cnt[r]} + 1'b1) >= {1'b0, cfg_threshold};

        // Per-rank error counter, cleared at each window end.
        always_ff @(posedge clk) begin
            if (!rst_n)                           cnt[r] <= '0;
            else if (wrap)                        cnt[r] <= '0;
            else if (hit_vec[r] && cnt[r] != '1)  cnt[r] <= cnt[r] + 1'b1;
        end

        a_r3_window_clear: assert property (@(posedge clk) disable iff (!rst_n)
            wrap |=> cnt[r] == '0);
    end

    assign trig = |(hit_vec & reach_vec);

    a_r3_timer_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_window != '0) |-> (tmr < cfg_window));
endmodule

// File: rtl/sfo_copier.sv
// Background copy and verify engine.
// After start, it copies every word of the source rank to the spare, then
// reads both ranks in parallel and compares them. It restarts the copy on a
// mismatch. Memory reads return data one cycle later and ignore writes made
// in the same cycle. A word is re-read if the host mirrored a write to that
// word during its read cycle, or used the spare port in its write cycle.
module sfo_copier
    import sfo_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int RW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RW-1:0]     src_rank,
    input  logic              mirror_now,
    input  logic [ADDR_W-1:0] mirror_addr,
    input  logic [DATA_W-1:0] a_rd_data,
    input  logic [DATA_W-1:0] b_rd_data,
    output logic              a_rd_valid,
    output logic [RW-1:0]     a_rd_rank,
    output logic [ADDR_W-1:0] a_rd_addr,
    output logic              b_rd_valid,
    output logic [ADDR_W-1:0] b_rd_addr,
    output logic              cp_wr_valid,
    output logic [ADDR_W-1:0] cp_wr_addr,
    output logic [DATA_W-1:0] cp_wr_data,
    output logic              copy_done,
    output logic              vfy_pass,
    output logic              vfy_fail
);
    sfo_phase_e        phase;
    logic [ADDR_W-1:0] addr;
    logic              retry;
    logic              last;
    logic              go_wr;
    logic              mism;

    assign last        = (addr == '1);
    assign go_wr       = (phase == PH_CWR) && !retry && !mirror_now;
    assign mism        = (phase == PH_VCMP) && (a_rd_data != b_rd_data);
    assign a_rd_valid  = (phase == PH_CRD) || (phase == PH_VRD);
    assign a_rd_rank   = src_rank;
    assign a_rd_addr   = addr;
    assign b_rd_valid  = (phase == PH_VRD);
    assign b_rd_addr   = addr;
    assign cp_wr_valid = go_wr;
    assign cp_wr_addr  = addr;
    assign cp_wr_data  = a_rd_data;
    assign copy_done   = go_wr && last;
    assign vfy_fail    = mism;
    assign vfy_pass    = (phase == PH_VCMP) && !mism && last;

    // Phase sequencer and address walker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            addr  <= '0;
            retry <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_CRD;
                    addr  <= '0;
                end
                PH_CRD: begin
                    phase <= PH_CWR;
                    retry <= mirror_now && (mirror_addr == addr);
                end
                PH_CWR: begin
                    if (go_wr) begin
                        addr  <= addr + 1'b1;
                        phase <= last ? PH_VRD : PH_CRD;
                    end else begin
                        phase <= PH_CRD;
                    end
                end
                PH_VRD: phase <= PH_VCMP;
                PH_VCMP: begin
                    if (mism) begin
                        phase <= PH_CRD;
                        addr  <= '0;
                    end else if (last) begin
                        phase <= PH_IDLE;
                    end else begin
                        addr  <= addr + 1'b1;
                        phase <= PH_VRD;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R5: after each committed copy word the engine reads the next address.
    a_r5_addr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        cp_wr_valid |=> a_rd_valid && (a_rd_addr == ($past(cp_wr_addr) + 1'b1)));
    // R6: a failed comparison restarts the copy at address zero.
    a_r6_fail_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        vfy_fail |=> a_rd_valid && !b_rd_valid && (a_rd_addr == '0));
endmodule

// File: rtl/sfo_write_router.sv
// Host write router.
// It drops writes to the spare ID and remaps the failed ID to the spare ID
// once spared. During migration and verify it flags writes that must also go
// to the spare. Purely combinational.
module sfo_write_router
    import sfo_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int RW     = 3,
    parameter int NRANK  = 4
) (
    input  sfo_state_e        state,
    input  logic [RW-1:0]     src_rank,
    input  logic              wr_valid,
    input  logic [RW-1:0]     wr_rank,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              m_wr_valid,
    output logic [RW-1:0]     m_wr_rank,
    output logic [ADDR_W-1:0] m_wr_addr,
    output logic [DATA_W-1:0] m_wr_data,
    output logic              mirror
);
    localparam logic [RW-1:0] SPARE_ID = RW'(NRANK);

    logic is_spare;
    logic to_src;
    logic dual;

    // Routing decision for the current host write.
    always_comb begin
        is_spare   = (wr_rank == SPARE_ID);
        to_src     = (wr_rank == src_rank);
        dual       = (state == ST_MIGRATE) || (state == ST_VERIFY);
        m_wr_valid = wr_valid && !is_spare;
        m_wr_rank  = ((state == ST_SPARED) && to_src) ? SPARE_ID : wr_rank;
        m_wr_addr  = wr_addr;
        m_wr_data  = wr_data;
        mirror     = wr_valid && !is_spare && to_src && dual;
    end
endmodule

// File: rtl/spare_failover_ctrl.sv
// Spare rank failover controller, top level.
// It holds the channel state and the failed-rank remap register, and muxes
// the spare write port between host mirror writes (priority) and the copy
// engine. Assumes the configuration is static outside reset and that the
// spare has rank ID NRANK.
module spare_failover_ctrl
    import sfo_pkg::*;
#(
    parameter int NRANK  = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4,
    parameter int WIN_W  = 8,
    localparam int RW    = $clog2(NRANK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_threshold,
    input  logic [WIN_W-1:0]  cfg_window,
    input  logic [ADDR_W:0]   cfg_spare_words,
    input  logic [ADDR_W:0]   cfg_rank_words,
    input  logic              err_valid,
    input  logic [RW-1:0]     err_rank,
    input  logic              wr_valid,
    input  logic [RW-1:0]     wr_rank,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              m_wr_valid,
    output logic [RW-1:0]     m_wr_rank,
    output logic [ADDR_W-1:0] m_wr_addr,
    output logic [DATA_W-1:0] m_wr_data,
    output logic              s_wr_valid,
    output logic [ADDR_W-1:0] s_wr_addr,
    output logic [DATA_W-1:0] s_wr_data,
    output logic              m_rd_valid,
    output logic [RW-1:0]     m_rd_rank,
    output logic [ADDR_W-1:0] m_rd_addr,
    input  logic [DATA_W-1:0] m_rd_data,
    output logic              s_rd_valid,
    output logic [ADDR_W-1:0] s_rd_addr,
    input  logic [DATA_W-1:0] s_rd_data,
    output logic [2:0]        status,
    output logic [RW-1:0]     failed_rank,
    output logic              alarm
);
    localparam logic [RW-1:0] SPARE_ID = RW'(NRANK);

    sfo_state_e        state;
    logic [RW-1:0]     failed_q;
    logic              alarm_q;
    logic              trig;
    logic              spare_ok;
    logic              start;
    logic              mirror;
    logic              cp_wr_valid;
    logic [ADDR_W-1:0] cp_wr_addr;
    logic [DATA_W-1:0] cp_wr_data;
    logic              copy_done;
    logic              vfy_pass;
    logic              vfy_fail;

    assign spare_ok = (cfg_spare_words >= cfg_rank_words);
    assign start    = (state == ST_NORMAL) && trig && spare_ok;

    sfo_err_monitor #(.NRANK(NRANK), .CNT_W(CNT_W), .WIN_W(WIN_W), .RW(RW)) u_mon (
        .clk(clk), .rst_n(rst_n), .cfg_threshold(cfg_threshold),
        .cfg_window(cfg_window), .err_valid(err_valid), .err_rank(err_rank),
        .trig(trig)
    );

    sfo_write_router #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RW(RW), .NRANK(NRANK)) u_rt (
        .state(state), .src_rank(failed_q), .wr_valid(wr_valid),
        .wr_rank(wr_rank), .wr_addr(wr_addr), .wr_data(wr_data),
        .m_wr_valid(m_wr_valid), .m_wr_rank(m_wr_rank), .m_wr_addr(m_wr_addr),
        .m_wr_data(m_wr_data), .mirror(mirror)
    );

    sfo_copier #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RW(RW)) u_cp (
        .clk(clk), .rst_n(rst_n), .start(start), .src_rank(failed_q),
        .mirror_now(mirror), .mirror_addr(wr_addr),
        .a_rd_data(m_rd_data), .b_rd_data(s_rd_data),
        .a_rd_valid(m_rd_valid), .a_rd_rank(m_rd_rank), .a_rd_addr(m_rd_addr),
        .b_rd_valid(s_rd_valid), .b_rd_addr(s_rd_addr),
        .cp_wr_valid(cp_wr_valid), .cp_wr_addr(cp_wr_addr), .cp_wr_data(cp_wr_data),
        .copy_done(copy_done), .vfy_pass(vfy_pass), .vfy_fail(vfy_fail)
    );

    // Spare write port: host mirror has priority over the copy engine.
    always_comb begin
        s_wr_valid = mirror || cp_wr_valid;
        s_wr_addr  = mirror ? wr_addr : cp_wr_addr;
        s_wr_data  = mirror ? wr_data : cp_wr_data;
    end

    // Channel state, remap register and sticky alarm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_NORMAL;
            failed_q <= '0;
            alarm_q  <= 1'b0;
        end else begin
            case (state)
                ST_NORMAL: if (trig) begin
                    failed_q <= err_rank;
                    state    <= spare_ok ? ST_MIGRATE : ST_NOSPARE;
                end
                ST_MIGRATE: if (copy_done) state <= ST_VERIFY;
                ST_VERIFY: begin
                    if (vfy_pass)      state <= ST_SPARED;
                    else if (vfy_fail) state <= ST_MIGRATE;
                end
                ST_SPARED, ST_NOSPARE: if (trig) alarm_q <= 1'b1;
                default: state <= ST_NORMAL;
            endcase
        end
    end

    assign status      = state;
    assign failed_rank = failed_q;
    assign alarm       = alarm_q;

    a_r2_spare_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SPARED) |-> !(m_wr_valid && m_wr_rank == SPARE_ID));
    a_r4_dual_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_rank == failed_q && (state == ST_MIGRATE || state == ST_VERIFY))
        |-> (s_wr_valid && s_wr_addr == wr_addr && s_wr_data == wr_data));
    a_r6_spared_after_verify: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_SPARED) |-> ($past(state) == ST_VERIFY));
    a_r7_failed_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SPARED) |-> !(m_wr_valid && m_wr_rank == failed_q));
    a_r8_no_spare_traffic: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NOSPARE) |-> !s_wr_valid);
    a_r9_spared_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SPARED) |=> (state == ST_SPARED));
endmodule

// File: tb/spare_failover_ctrl_test.sv
// Self-checking bench for spare_failover_ctrl with a behavioural memory model.
module spare_failover_ctrl_test;
    localparam int CLK_P  = 10;
    localparam int NRANK  = 4;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 4;
    localparam int WIN_W  = 8;
    localparam int RW     = 3;
    localparam int DEPTH  = 16;
    localparam int WIN    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CNT_W-1:0] cfg_threshold = 4'd3;
    logic [WIN_W-1:0] cfg_window = 8'(WIN);
    logic [ADDR_W:0] cfg_spare_words = 5'd16;
    logic [ADDR_W:0] cfg_rank_words = 5'd16;
    logic err_valid = 1'b0;
    logic [RW-1:0] err_rank = '0;
    logic wr_valid = 1'b0;
    logic [RW-1:0] wr_rank = '0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic m_wr_valid, s_wr_valid, m_rd_valid, s_rd_valid, alarm;
    logic [RW-1:0] m_wr_rank, m_rd_rank, failed_rank;
    logic [ADDR_W-1:0] m_wr_addr, s_wr_addr, m_rd_addr, s_rd_addr;
    logic [DATA_W-1:0] m_wr_data, s_wr_data, m_rd_data, s_rd_data;
    logic [2:0] status;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic corrupt_req = 1'b0;
    logic [DATA_W-1:0] mem [0:NRANK][0:DEPTH-1];

    always #(CLK_P/2) clk = ~clk;

    spare_failover_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_threshold(cfg_threshold),
        .cfg_window(cfg_window), .cfg_spare_words(cfg_spare_words),
        .cfg_rank_words(cfg_rank_words), .err_valid(err_valid), .err_rank(err_rank),
        .wr_valid(wr_valid), .wr_rank(wr_rank), .wr_addr(wr_addr), .wr_data(wr_data),
        .m_wr_valid(m_wr_valid), .m_wr_rank(m_wr_rank), .m_wr_addr(m_wr_addr),
        .m_wr_data(m_wr_data), .s_wr_valid(s_wr_valid), .s_wr_addr(s_wr_addr),
        .s_wr_data(s_wr_data), .m_rd_valid(m_rd_valid), .m_rd_rank(m_rd_rank),
        .m_rd_addr(m_rd_addr), .m_rd_data(m_rd_data), .s_rd_valid(s_rd_valid),
        .s_rd_addr(s_rd_addr), .s_rd_data(s_rd_data), .status(status),
        .failed_rank(failed_rank), .alarm(alarm)
    );

    // Memory model: writes land at the edge, reads return old data one cycle later.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r <= NRANK; r++)
                for (int a = 0; a < DEPTH; a++)
                    mem[r][a] <= (r == NRANK) ? 8'hEE : 8'(r * 16 + a);
        end else begin
            if (m_wr_valid) mem[m_wr_rank][m_wr_addr] <= m_wr_data;
            if (s_wr_valid) mem[NRANK][s_wr_addr] <= s_wr_data;
            if (corrupt_req) mem[NRANK][DEPTH-1] <= ~mem[NRANK][DEPTH-1];
            m_rd_data <= mem[m_rd_rank][m_rd_addr];
            s_rd_data <= mem[NRANK][s_rd_addr];
        end
    end

    // Cycles since reset release, matching the window timer phase (R3).
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    // Vector table: {host rank, expect primary write, expected primary rank}.
    localparam logic [6:0] VEC [5] = '{
        {3'd0, 1'b1, 3'd0}, {3'd1, 1'b1, 3'd1}, {3'd4, 1'b0, 3'd0},
        {3'd3, 1'b1, 3'd3}, {3'd2, 1'b1, 3'd2}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic align(input int ph);
        @(negedge clk);
        while (cyc % WIN != ph) @(negedge clk);
    endtask

    task automatic pulse_errs(input logic [RW-1:0] rk, input int n);
        for (int i = 0; i < n; i++) begin
            err_valid = 1'b1;
            err_rank  = rk;
            @(negedge clk);
        end
        err_valid = 1'b0;
        #1;
    endtask

    task automatic host_wr(input logic [RW-1:0] rk, input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] d);
        wr_valid = 1'b1; wr_rank = rk; wr_addr = a; wr_data = d;
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int  mism;
        bit  seen;
        logic [2:0] prev;
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(status == 3'd0 && alarm == 1'b0, "R1 reset status/alarm", status, 0);
        check(!s_wr_valid && !m_rd_valid, "R1 reset no memory traffic", s_wr_valid, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(status == 3'd0 && !m_rd_valid, "R1 after release", status, 0);

        // R2: table of host writes in normal state.
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            host_wr(VEC[i][6:4], 4'(i), 8'(8'h40 + i));
            check(m_wr_valid == VEC[i][3], "R2 write pass/drop", m_wr_valid, VEC[i][3]);
            if (VEC[i][3])
                check(m_wr_rank == VEC[i][2:0] && m_wr_data == 8'(8'h40 + i),
                      "R2 write rank/data", m_wr_rank, VEC[i][2:0]);
        end
        @(negedge clk); wr_valid = 1'b0;

        // R3: errors split across two windows do not trigger.
        align(2); pulse_errs(3'd1, 2);
        align(2); pulse_errs(3'd1, 1);
        check(status == 3'd0, "R3 split window no trigger", status, 0);

        // R3: three errors in one window trigger on the next clock.
        align(2); pulse_errs(3'd1, 2);
        check(status == 3'd0, "R3 below threshold", status, 0);
        pulse_errs(3'd1, 1);
        check(status == 3'd1 && failed_rank == 3'd1, "R3 trigger to migrating", status, 1);

        // R4: dual write to failing rank, none for another rank.
        host_wr(3'd1, 4'd5, 8'hA5);
        check(m_wr_valid && m_wr_rank == 3'd1 && s_wr_valid && s_wr_addr == 4'd5
              && s_wr_data == 8'hA5, "R4 mirror write", s_wr_data, 8'hA5);
        @(negedge clk);
        host_wr(3'd2, 4'd5, 8'h5C);
        check(!(s_wr_valid && s_wr_data == 8'h5C), "R4 other rank not mirrored", s_wr_data, 0);
        @(negedge clk); wr_valid = 1'b0;

        // R5/R6: host traffic during the copy, until verify starts.
        seen = 1'b0;
        for (int i = 0; i < 600 && !seen; i++) begin
            @(negedge clk); #1;
            if (status == 3'd2) seen = 1'b1;
            else if (i % 5 == 2) host_wr(3'd1, 4'((i * 3) % 16), 8'(8'h80 + i % 64));
            else wr_valid = 1'b0;
        end
        wr_valid = 1'b0;
        check(seen, "R6 reached verify", status, 2);

        // R6: corrupt the spare during verify, expect a return to migrating.
        corrupt_req = 1'b1;
        @(negedge clk); corrupt_req = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 60 && !seen; i++) begin
            #1; if (status == 3'd1) seen = 1'b1;
            @(negedge clk);
        end
        check(seen, "R6 mismatch returns to migrating", status, 1);

        // R6: spared only straight from verify.
        seen = 1'b0; prev = status;
        for (int i = 0; i < 600 && !seen; i++) begin
            @(negedge clk); #1;
            if (status == 3'd3) seen = 1'b1; else prev = status;
        end
        check(seen && prev == 3'd2, "R6 verify then spared", prev, 2);

        // R5: spare equals failing rank everywhere.
        mism = 0;
        for (int a = 0; a < DEPTH; a++) if (mem[NRANK][a] != mem[1][a]) mism++;
        check(mism == 0, "R5 spare matches failing rank", mism, 0);

        // R7: remap of the failed rank to the spare ID.
        @(negedge clk);
        host_wr(3'd1, 4'd2, 8'h33);
        check(m_wr_valid && m_wr_rank == 3'd4 && !s_wr_valid, "R7 remap to spare", m_wr_rank, 4);
        @(negedge clk);
        host_wr(3'd4, 4'd2, 8'h34);
        check(!m_wr_valid, "R2 spare ID still dropped", m_wr_valid, 0);
        @(negedge clk); wr_valid = 1'b0;

        // R9: further burst only raises the alarm.
        check(alarm == 1'b0, "R9 alarm clear before burst", alarm, 0);
        align(2); pulse_errs(3'd2, 3);
        check(alarm == 1'b1 && status == 3'd3, "R9 alarm after sparing", {alarm, status}, 4'hB);

        // R8: spare too small.
        rst_n = 1'b0; cfg_spare_words = 5'd8;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(status == 3'd0 && alarm == 1'b0, "R1 second reset", status, 0);
        align(2); pulse_errs(3'd0, 3);
        check(status == 3'd4 && failed_rank == 3'd0, "R8 no spare state", status, 4);
        host_wr(3'd0, 4'd1, 8'h77);
        check(m_wr_valid && m_wr_rank == 3'd0 && !s_wr_valid, "R8 no mirror", s_wr_valid, 0);
        @(negedge clk); wr_valid = 1'b0;
        repeat (40) @(negedge clk);
        #1;
        check(status == 3'd4 && !m_rd_valid, "R8 no copy traffic", status, 4);
        summary();
    end
endmodule